// File: doc/BRIEF.md
# PWM Dead-Band Generator

This block turns one or two PWM waveforms into a pair of gate-drive signals for a half bridge. One path holds back rising edges and the other holds back falling edges, so the high-side and low-side switches are never on together. Each delay has its own count. Register-style inputs choose which input feeds each delay path, whether each path is inverted, whether each output uses its delay or the raw input, and whether the two outputs are exchanged.

The whole block runs on one clock at twice the time-base rate. The `tb_en` input marks every other clock as a time-base tick. When half-cycle mode is off, the delay logic advances only on ticks, so one count lasts one time-base period. When half-cycle mode is on, the logic advances on every clock, so one count lasts half a period.

The delay counts have two levels. The `red_cfg` and `fed_cfg` inputs act as shadow values. With shadowing off, they are copied into the active counts on every clock. With shadowing on, they are copied only when `load_strb` pulses, for example at time-base counter zero. A delay uses the active count in force at the input edge that starts it.

Top module: `deadband_gen`

## Requirements
- R1: While reset is asserted, all delay stages and input samples are zero. With output mode 3 and polarity 2, `gate_a` is 0 and `gate_b` is 1.
- R2: A "step" is a clock with `tb_en`=1, or any clock when `half_cyc`=1. The rising-delay path samples its source on each step. Its output rises D steps after the step that first samples the source high (D is the active rising count). It falls on the step that samples the source low.
- R3: The falling-delay path mirrors R2. Its output falls D steps after the step that first samples the source low, and rises on the step that samples the source high. After reset it is 0 until the source is first sampled high.
- R4: A source pulse lasting D or fewer steps never reaches the delayed output, and each new edge restarts that path's delay.
- R5: A count of 0 moves the edge to the output on the same step that samples it, which is one register stage.
- R6: With `half_cyc`=0, the delay logic and the input samples change only on clocks where `tb_en`=1. With `half_cyc`=1, they advance on every clock, which halves the delay time per count.
- R7: `pol_sel` bit 0 inverts the rising-delay result on path A. Bit 1 inverts the falling-delay result on path B. Value 2 gives active-high complementary outputs.
- R8: `in_mode` bit 0 set takes the rising-delay source from `in_b`, otherwise from `in_a`. Bit 1 set takes the falling-delay source from `in_b`, otherwise from `in_a`. Value 0 feeds both paths from `in_a`.
- R9: `out_mode` bit 1 selects the polarity-adjusted rising-delay result for path A, otherwise the step-sampled `in_a`. Bit 0 does the same for path B, using the falling-delay result or the step-sampled `in_b`. Value 0 bypasses both delays and both polarity inversions.
- R10: `out_swap` bit 0 drives `gate_a` from path B instead of path A. Bit 1 drives `gate_b` from path A instead of path B. Value 0 means no exchange.
- R11: With `shd_en`=0, the active counts take `red_cfg`/`fed_cfg` on every clock. With `shd_en`=1, they change only on a clock where `load_strb`=1. An edge in that same clock still uses the old count.
- R12: A change to the active count while a delay is running does not alter that delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the time-base rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| tb_en | input | 1 | Time-base tick enable, high on every other clock |
| half_cyc | input | 1 | 1 = delay logic advances on every clock |
| in_a | input | 1 | PWM input A |
| in_b | input | 1 | PWM input B |
| out_mode | input | 2 | Delay use per output path |
| pol_sel | input | 2 | Inversion per delay path |
| in_mode | input | 2 | Source select per delay path |
| out_swap | input | 2 | Output exchange control |
| shd_en | input | 1 | 1 = active counts load only on load_strb |
| load_strb | input | 1 | Shadow-to-active load event |
| red_cfg | input | CNT_W | Rising-edge delay count, shadow value |
| fed_cfg | input | CNT_W | Falling-edge delay count, shadow value |
| gate_a | output | 1 | Gate drive output A |
| gate_b | output | 1 | Gate drive output B |

## Verification
Two things can land in the same clock: a shadow load and an input edge that starts a delay. The bench sets up this collision on purpose. It raises `in_a` on the same clock that pulses `load_strb`, with a new count waiting in the shadow. It then compares the outputs on every clock against a behavioural model that tracks run lengths and captures counts. The model expects the old count to govern that edge and the new count to govern the next one.

// File: rtl/deadband_gen.sv
module deadband_gen #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tb_en,
  input  logic             half_cyc,
  input  logic             in_a,
  input  logic             in_b,
  input  logic [1:0]       out_mode,
  input  logic [1:0]       pol_sel,
  input  logic [1:0]       in_mode,
  input  logic [1:0]       out_swap,
  input  logic             shd_en,
  input  logic             load_strb,
  input  logic [CNT_W-1:0] red_cfg,
  input  logic [CNT_W-1:0] fed_cfg,
  output logic             gate_a,
  output logic             gate_b
);

  logic             step, rs, fs;
  logic             ra_q, rb_q, red_src_q, fed_src_q, red_o, fed_o;
  logic [CNT_W-1:0] red_act, fed_act, red_cnt, fed_cnt;
  logic             path_a, path_b;

  assign step = half_cyc | tb_en;
  assign rs   = in_mode[0] ? in_b : in_a;
  assign fs   = in_mode[1] ? in_b : in_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      red_act <= '0;
      fed_act <= '0;
    end else if (!shd_en || load_strb) begin
      red_act <= red_cfg;
      fed_act <= fed_cfg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ra_q <= 1'b0;
      rb_q <= 1'b0;
    end else if (step) begin
      ra_q <= in_a;
      rb_q <= in_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      red_src_q <= 1'b0;
      red_o     <= 1'b0;
      red_cnt   <= '0;
    end else if (step) begin
      red_src_q <= rs;
      if (!rs) begin
        red_o   <= 1'b0;
        red_cnt <= '0;
      end else if (!red_src_q) begin
        if (red_act == '0) red_o <= 1'b1;
        else               red_cnt <= red_act;
      end else if (!red_o && red_cnt != '0) begin
        if (red_cnt == CNT_W'(1)) red_o <= 1'b1;
        red_cnt <= red_cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fed_src_q <= 1'b0;
      fed_o     <= 1'b0;
      fed_cnt   <= '0;
    end else if (step) begin
      fed_src_q <= fs;
      if (fs) begin
        fed_o   <= 1'b1;
        fed_cnt <= '0;
      end else if (fed_src_q) begin
        if (fed_act == '0) fed_o <= 1'b0;
        else               fed_cnt <= fed_act;
      end else if (fed_o && fed_cnt != '0) begin
        if (fed_cnt == CNT_W'(1)) fed_o <= 1'b0;
        fed_cnt <= fed_cnt - 1'b1;
      end
    end
  end

  assign path_a = out_mode[1] ? (red_o ^ pol_sel[0]) : ra_q;
  assign path_b = out_mode[0] ? (fed_o ^ pol_sel[1]) : rb_q;
  assign gate_a = out_swap[0] ? path_b : path_a;
  assign gate_b = out_swap[1] ? path_a : path_b;

endmodule

// File: rtl/db_chk.sv
module db_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step,
  input logic             rs,
  input logic             fs,
  input logic             red_src_q,
  input logic             red_o,
  input logic             fed_o,
  input logic             ra_q,
  input logic             rb_q,
  input logic             shd_en,
  input logic             load_strb,
  input logic [CNT_W-1:0] red_act,
  input logic [CNT_W-1:0] fed_act,
  input logic [1:0]       out_mode,
  input logic [1:0]       out_swap,
  input logic             gate_a,
  input logic             gate_b
);

  AST_RED_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !rs) |=> !red_o); // R2

  AST_FED_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (step && fs) |=> fed_o); // R3

  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (step && rs && !red_src_q && red_act == '0) |=> red_o); // R5

  AST_HOLD_OFF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(red_o) && $stable(fed_o) && $stable(ra_q) && $stable(rb_q))); // R6

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (shd_en && !load_strb) |=> ($stable(red_act) && $stable(fed_act))); // R11

  AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode == 2'd0 && out_swap == 2'd0) |-> (gate_a == ra_q && gate_b == rb_q)); // R9

endmodule

bind deadband_gen db_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .rs(rs), .fs(fs),
  .red_src_q(red_src_q), .red_o(red_o), .fed_o(fed_o),
  .ra_q(ra_q), .rb_q(rb_q), .shd_en(shd_en), .load_strb(load_strb),
  .red_act(red_act), .fed_act(fed_act), .out_mode(out_mode),
  .out_swap(out_swap), .gate_a(gate_a), .gate_b(gate_b)
);

// File: tb/sim_deadband_gen.sv
module sim_deadband_gen;
  localparam int W = 10;

  logic clk = 1'b0, rst_n = 1'b0, tb_en = 1'b0, half_cyc = 1'b0;
  logic in_a = 1'b0, in_b = 1'b0, shd_en = 1'b0, load_strb = 1'b0;
  logic [1:0] out_mode = 2'd3, pol_sel = 2'd2, in_mode = 2'd0, out_swap = 2'd0;
  logic [W-1:0] red_cfg = 10'd5, fed_cfg = 10'd5;
  logic gate_a, gate_b;

  int checks = 0, errors = 0;
  bit running = 1'b0, done = 1'b0;
  string tag = "R1";

  // reference model state
  int r_run, f_run, r_d, f_d, act_red, act_fed;
  bit r_prev, f_prev, m_red, m_fed, m_ra, m_rb;

  deadband_gen #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .half_cyc(half_cyc),
    .in_a(in_a), .in_b(in_b), .out_mode(out_mode), .pol_sel(pol_sel),
    .in_mode(in_mode), .out_swap(out_swap), .shd_en(shd_en),
    .load_strb(load_strb), .red_cfg(red_cfg), .fed_cfg(fed_cfg),
    .gate_a(gate_a), .gate_b(gate_b)
  );

  always #5 clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      #2 tb_en = ~tb_en;
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_run = 0; f_run = 1000000; r_d = 0; f_d = 0;
      act_red = 0; act_fed = 0; r_prev = 0; f_prev = 0;
      m_red = 0; m_fed = 0; m_ra = 0; m_rb = 0;
    end else begin
      if (half_cyc || tb_en) begin
        bit rsrc, fsrc;
        rsrc = in_mode[0] ? in_b : in_a;
        fsrc = in_mode[1] ? in_b : in_a;
        if (rsrc) begin
          if (!r_prev) begin r_run = 0; r_d = act_red; end
          r_run++;
        end else r_run = 0;
        if (!fsrc) begin
          if (f_prev) begin f_run = 0; f_d = act_fed; end
          f_run++;
        end else f_run = 0;
        m_red = rsrc && (r_run >= r_d + 1);
        m_fed = !(!fsrc && (f_run >= f_d + 1));
        r_prev = rsrc; f_prev = fsrc;
        m_ra = in_a; m_rb = in_b;
      end
      if (!shd_en || load_strb) begin
        act_red = int'(red_cfg);
        act_fed = int'(fed_cfg);
      end
    end
  end

  always @(negedge clk) begin
    if (running && rst_n) begin
      bit pa, pb, ea, eb;
      pa = out_mode[1] ? (m_red ^ pol_sel[0]) : m_ra;
      pb = out_mode[0] ? (m_fed ^ pol_sel[1]) : m_rb;
      ea = out_swap[0] ? pb : pa;
      eb = out_swap[1] ? pa : pb;
      checks++;
      if (gate_a !== ea || gate_b !== eb) begin
        errors++;
        $display("FAIL %s: gate_a=%b gate_b=%b expected %b %b at %0t",
                 tag, gate_a, gate_b, ea, eb, $time);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulses(input int hi, input int lo, input int reps);
    for (int i = 0; i < reps; i++) begin
      in_a = 1'b1; tick(hi);
      in_a = 1'b0; tick(lo);
    end
  endtask

  task automatic rnd(input int segs, input int maxw);
    for (int i = 0; i < segs; i++) begin
      in_a = 1'($urandom % 2);
      in_b = 1'($urandom % 2);
      tick(1 + int'($urandom % maxw));
    end
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    summary();
  end

  initial begin
    tick(3);
    checks++;
    if (gate_a !== 1'b0 || gate_b !== 1'b1) begin
      errors++;
      $display("FAIL R1: gate_a=%b gate_b=%b expected 0 1", gate_a, gate_b);
    end
    rst_n = 1'b1;
    running = 1'b1;
    tick(4);

    tag = "R2 R3"; red_cfg = 10'd5; fed_cfg = 10'd3;
    pulses(30, 30, 3);
    tag = "R5"; red_cfg = 10'd0; fed_cfg = 10'd0;
    pulses(6, 8, 4); rnd(30, 4);
    tag = "R4"; red_cfg = 10'd6; fed_cfg = 10'd6;
    for (int w = 1; w <= 16; w++) pulses(w, w, 1);
    rnd(60, 14);
    tag = "R6"; half_cyc = 1'b1; red_cfg = 10'd5; fed_cfg = 10'd5;
    pulses(20, 20, 2); pulses(3, 3, 3); rnd(40, 12);
    half_cyc = 1'b0;
    tag = "R7";
    for (int p = 0; p < 4; p++) begin pol_sel = 2'(p); pulses(24, 24, 2); end
    pol_sel = 2'd2;
    tag = "R8"; red_cfg = 10'd3; fed_cfg = 10'd4;
    for (int m = 0; m < 4; m++) begin in_mode = 2'(m); rnd(40, 16); end
    in_mode = 2'd0;
    tag = "R9";
    for (int m = 0; m < 4; m++) begin out_mode = 2'(m); rnd(40, 16); end
    out_mode = 2'd3;
    tag = "R10";
    for (int s = 0; s < 4; s++) begin out_swap = 2'(s); rnd(30, 16); pulses(20, 20, 1); end
    out_swap = 2'd0;
    tag = "R11"; in_a = 1'b0; in_b = 1'b0; tick(20);
    shd_en = 1'b1; red_cfg = 10'd2; fed_cfg = 10'd2; tick(1);
    red_cfg = 10'd9; fed_cfg = 10'd7;
    pulses(24, 24, 2);
    in_a = 1'b1; load_strb = 1'b1; tick(1);
    load_strb = 1'b0; tick(29);
    in_a = 1'b0; tick(30);
    pulses(24, 24, 2);
    shd_en = 1'b0;
    tag = "R12"; red_cfg = 10'd8; fed_cfg = 10'd8; tick(4);
    in_a = 1'b1; tick(4);
    red_cfg = 10'd1; tick(30);
    in_a = 1'b0; tick(4);
    fed_cfg = 10'd1; tick(30);
    pulses(20, 20, 2);
    running = 1'b0;
    summary();
  end
endmodule